// File: doc/BRIEF.md
# Bi-endian load/store byte-lane aligner

This block sits between a processor's load/store unit and a 32-bit memory bus whose byte lanes are wired little-endian: lane k carries the byte whose address ends in k. Each access request gives an access size, a byte address and an ordering mode. For a store, the block places the register value on the correct lanes, raises the matching lane enables and zeroes every lane it does not use. For a load, the bus word must come in the same cycle as the request. The block collects the bytes of interest, puts them in value order, and sign- or zero-extends them to 32 bits.

Four ordering modes are supported. Little-endian puts the least significant byte at the lowest address. Byte-invariant big-endian leaves single bytes where little-endian puts them and reverses the bytes of halfwords and words. Word-invariant big-endian keeps aligned words unchanged and steers bytes and halfwords to a different position inside the word. Mixed ordering keeps a word as two little-endian halves with the upper half at the lower address. Misaligned accesses raise a fault and touch no lane. The ordering logic is combinational, and all results appear through one register stage, one clock after the request.

Top module: `lane_aligner`

## Requirements
- R1: While reset is asserted and on the first sampled cycle after it, `o_valid` is 0 and `o_lane_en` is 0.
- R2: Every cycle with `req_valid` high produces exactly one result with `o_valid` high one clock later. `o_word_addr` then equals the request address with its two low bits dropped. A cycle without a request gives `o_valid` low one clock later.
- R3: Mode code 0 (little-endian): the access uses lanes starting at `req_addr[1:0]`, and value byte k maps to lane `req_addr[1:0]`+k. Example: lanes holding 4A 00 00 00 load as 0x4A, 0x004A or 0x0000004A at sizes byte, halfword and word.
- R4: Mode code 1 (byte-invariant big-endian), byte size: lane and data are the same as in mode 0.
- R5: Mode code 1, halfword or word size: the same lanes as mode 0 are used, with the byte order reversed, so the most significant value byte sits at the lowest address.
- R6: Mode code 2 (word-invariant big-endian), word size: data and lanes are the same as mode 0.
- R7: Mode code 2, byte size uses lane `req_addr[1:0]` XOR 3. Halfword size starts at lane `req_addr[1:0]` XOR 2. In both cases the bytes within the access keep little-endian order.
- R8: Mode code 3 (mixed): a word keeps the two value halves little-endian each, with the upper half at lanes 0-1. A store of 0x0A0B0C0D therefore gives lanes 0..3 = 0B 0A 0D 0C. Bytes and halfwords behave as in mode 0.
- R9: Size codes are 0 byte, 1 halfword, 2 word and 3 reserved. `o_fault` is 1 in every mode for: a halfword with address bit 0 set, a word with nonzero address bits [1:0], or size code 3. A faulting result has `o_lane_en`, `o_wdata` and `o_rdata` all zero.
- R10: For a store, `o_lane_en` has exactly the lanes written, and every byte of `o_wdata` outside those lanes is zero. A load drives `o_wdata` to zero and `o_store` low.
- R11: For a load, `req_signed`=1 sign-extends byte and halfword results to 32 bits, and `req_signed`=0 zero-extends them. A non-faulting store returns `o_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_mode | input | 2 | 0 little, 1 byte-invariant big, 2 word-invariant big, 3 mixed |
| req_signed | input | 1 | Load sign-extension select |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 32 | Register value to store, value-aligned at bit 0 |
| bus_rdata | input | 32 | Bus word for a load, same cycle as the request |
| o_valid | output | 1 | Result valid |
| o_store | output | 1 | Result belongs to a store |
| o_word_addr | output | ADDR_W-2 | Word address placed on the bus |
| o_lane_en | output | 4 | Byte-lane enables |
| o_wdata | output | 32 | Lane-placed store data |
| o_rdata | output | 32 | Ordered, extended load result |
| o_fault | output | 1 | Alignment fault |

## Verification
The bench builds the block with `ADDR_W` = 20, a narrower address than the default. This shows that the word address is taken from the upper bits alone, whatever the redirection does to the low bits. The bench sweeps every combination of mode, size code, low address bits, direction and extension select. That run reaches every fault case and all lane-steering paths. Directed accesses then repeat the worked values from the requirements.

// File: rtl/lane_pkg.sv
// Shared encodings and the per-lane byte-order rule for the lane aligner.
// Assumes a 32-bit bus split into four 8-bit lanes.
package lane_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        ORD_LE      = 2'd0,
        ORD_BE_BYTE = 2'd1,
        ORD_BE_WORD = 2'd2,
        ORD_MIXED   = 2'd3
    } order_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // Which value byte belongs at position rel (0 = lowest address) of an
    // access. Each mapping is its own inverse, so loads use it as well.
    function automatic logic [1:0] value_byte_of(order_mode_e m, acc_size_e s,
                                                 logic [1:0] rel);
        logic [1:0] r;
        r = rel;
        if (m == ORD_BE_BYTE) begin
            if (s == SZ_HALF)      r = {1'b0, ~rel[0]};
            else if (s == SZ_WORD) r = ~rel;
        end else if (m == ORD_MIXED && s == SZ_WORD) begin
            r = rel ^ 2'b10;
        end
        return r;
    endfunction
endpackage

// File: rtl/lane_addr_map.sv
// Address side of the aligner: alignment check, word-invariant lane
// redirection and lane-enable generation. Purely combinational.
module lane_addr_map
    import lane_pkg::*;
(
    input  order_mode_e      mode,
    input  acc_size_e        size,
    input  logic [1:0]       addr_lo,
    output logic [1:0]       base,
    output logic [LANES-1:0] lane_en,
    output logic             misaligned
);
    // Flag sizes and offsets that break natural alignment.
    always_comb begin
        misaligned = (size == SZ_RSVD)
                   || (size == SZ_HALF && addr_lo[0])
                   || (size == SZ_WORD && addr_lo != 2'b00);
    end

    // Lowest lane touched; word-invariant mode flips the low address bits.
    always_comb begin
        base = addr_lo;
        if (mode == ORD_BE_WORD) begin
            if (size == SZ_BYTE)      base = addr_lo ^ 2'b11;
            else if (size == SZ_HALF) base = addr_lo ^ 2'b10;
        end
    end

    // Contiguous lane enables from the base lane, suppressed on a fault.
    always_comb begin
        unique case (size)
            SZ_BYTE: lane_en = 4'b0001 << base;
            SZ_HALF: lane_en = 4'b0011 << base;
            SZ_WORD: lane_en = 4'b1111;
            default: lane_en = 4'b0000;
        endcase
        if (misaligned) lane_en = '0;
    end
endmodule

// File: rtl/lane_order.sv
// Data side of the aligner: places store bytes on bus lanes and gathers
// load bytes into value order. Lanes outside the access are not masked here.
module lane_order
    import lane_pkg::*;
(
    input  order_mode_e       mode,
    input  acc_size_e         size,
    input  logic [1:0]        base,
    input  logic [DATA_W-1:0] st_value,
    input  logic [DATA_W-1:0] bus_word,
    output logic [DATA_W-1:0] st_lanes,
    output logic [DATA_W-1:0] ld_value
);
    for (genvar L = 0; L < LANES; L++) begin : g_store
        logic [1:0] rel;
        logic [1:0] src;
        assign rel = 2'(L) - base;
        assign src = value_byte_of(mode, size, rel);
        // Lane L takes the value byte that its address position calls for.
        assign st_lanes[L*LANE_W +: LANE_W] = st_value[{src, 3'b000} +: LANE_W];
    end

    for (genvar J = 0; J < LANES; J++) begin : g_load
        logic [1:0] lane;
        assign lane = base + value_byte_of(mode, size, 2'(J));
        // Value byte J comes from the lane whose position maps to it.
        assign ld_value[J*LANE_W +: LANE_W] = bus_word[{lane, 3'b000} +: LANE_W];
    end
endmodule

// File: rtl/lane_extend.sv
// Sign or zero extension of a gathered load value to the full width.
module lane_extend
    import lane_pkg::*;
(
    input  acc_size_e         size,
    input  logic              sign_en,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] extended
);
    // Fill the upper bits from the top bit of the accessed size when signed.
    always_comb begin
        unique case (size)
            SZ_BYTE: extended = {{(DATA_W-8){sign_en & raw[7]}},   raw[7:0]};
            SZ_HALF: extended = {{(DATA_W-16){sign_en & raw[15]}}, raw[15:0]};
            default: extended = raw;
        endcase
    end
endmodule

// File: rtl/lane_aligner.sv
// Bi-endian byte-lane aligner between a load/store unit and a little-endian
// wired 32-bit bus. Combinational ordering with one output register stage.
// Assumes the bus word for a load arrives in the same cycle as the request.
module lane_aligner
    import lane_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic [1:0]        req_mode,
    input  logic              req_signed,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [31:0]       bus_rdata,
    output logic              o_valid,
    output logic              o_store,
    output logic [ADDR_W-3:0] o_word_addr,
    output logic [3:0]        o_lane_en,
    output logic [31:0]       o_wdata,
    output logic [31:0]       o_rdata,
    output logic              o_fault
);
    localparam int WA_W = ADDR_W - 2;

    order_mode_e       mode;
    acc_size_e         size;
    logic [1:0]        base;
    logic [LANES-1:0]  lane_en;
    logic              misaligned;
    logic [DATA_W-1:0] st_lanes;
    logic [DATA_W-1:0] ld_raw;
    logic [DATA_W-1:0] ld_ext;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] nxt_wdata;
    logic [DATA_W-1:0] nxt_rdata;

    assign mode = order_mode_e'(req_mode);
    assign size = acc_size_e'(req_size);

    lane_addr_map u_map (
        .mode      (mode),
        .size      (size),
        .addr_lo   (req_addr[1:0]),
        .base      (base),
        .lane_en   (lane_en),
        .misaligned(misaligned)
    );

    lane_order u_ord (
        .mode    (mode),
        .size    (size),
        .base    (base),
        .st_value(req_wdata),
        .bus_word(bus_rdata),
        .st_lanes(st_lanes),
        .ld_value(ld_raw)
    );

    lane_extend u_ext (
        .size    (size),
        .sign_en (req_signed),
        .raw     (ld_raw),
        .extended(ld_ext)
    );

    for (genvar L = 0; L < LANES; L++) begin : g_mask
        assign lane_mask[L*LANE_W +: LANE_W] = {LANE_W{lane_en[L]}};
    end

    // Select per-direction results; the unused direction reads as zero.
    always_comb begin
        nxt_wdata = req_store ? (st_lanes & lane_mask) : '0;
        nxt_rdata = (!req_store && !misaligned) ? ld_ext : '0;
    end

    // Output register stage; idle cycles clear valid, enables and fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid     <= 1'b0;
            o_store     <= 1'b0;
            o_word_addr <= '0;
            o_lane_en   <= '0;
            o_wdata     <= '0;
            o_rdata     <= '0;
            o_fault     <= 1'b0;
        end else begin
            o_valid <= req_valid;
            if (req_valid) begin
                o_store     <= req_store;
                o_word_addr <= req_addr[ADDR_W-1:2];
                o_lane_en   <= lane_en;
                o_wdata     <= nxt_wdata;
                o_rdata     <= nxt_rdata;
                o_fault     <= misaligned;
            end else begin
                o_lane_en <= '0;
                o_fault   <= 1'b0;
            end
        end
    end

    logic [WA_W-1:0] unused_wa;
    assign unused_wa = o_word_addr;
endmodule

// File: rtl/lane_aligner_chk.sv
// Property checker for lane_aligner, attached by bind. It observes the
// ports only.
module lane_aligner_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_store,
    input logic [1:0]        req_size,
    input logic [1:0]        req_mode,
    input logic              req_signed,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic [31:0]       bus_rdata,
    input logic              o_valid,
    input logic              o_store,
    input logic [ADDR_W-3:0] o_word_addr,
    input logic [3:0]        o_lane_en,
    input logic [31:0]       o_wdata,
    input logic [31:0]       o_rdata,
    input logic              o_fault
);
    logic [31:0] en_mask;
    assign en_mask = {{8{o_lane_en[3]}}, {8{o_lane_en[2]}},
                      {8{o_lane_en[1]}}, {8{o_lane_en[0]}}};

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> o_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !o_valid);

    assert_word_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> o_word_addr == $past(req_addr[ADDR_W-1:2]));

    assert_fault_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_fault) |-> (o_lane_en == 4'b0 && o_wdata == 32'b0 && o_rdata == 32'b0));

    assert_lane_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_fault) |-> ($countones(o_lane_en) == (32'd1 << $past(req_size))));

    assert_unused_wdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_store) |-> ((o_wdata & ~en_mask) == 32'b0));

    assert_load_no_wdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_store) |-> (o_wdata == 32'b0));

    assert_byte_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_fault && $past(req_mode) == 2'd2 && $past(req_size) == 2'd0)
        |-> (o_lane_en == (4'b0001 << ($past(req_addr[1:0]) ^ 2'b11))));
endmodule

bind lane_aligner lane_aligner_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_lane_aligner.sv
`timescale 1ns/1ps
module sim_lane_aligner;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_store = 1'b0;
    logic [1:0]    req_size = '0;
    logic [1:0]    req_mode = '0;
    logic          req_signed = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   bus_rdata = '0;
    logic          o_valid, o_store, o_fault;
    logic [AW-3:0] o_word_addr;
    logic [3:0]    o_lane_en;
    logic [31:0]   o_wdata, o_rdata;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit          st;
        bit          flt;
        logic [3:0]  en;
        logic [31:0] wd;
        logic [31:0] rd;
        logic [AW-3:0] wa;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    lane_aligner #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_mode(req_mode), .req_signed(req_signed),
        .req_addr(req_addr), .req_wdata(req_wdata), .bus_rdata(bus_rdata),
        .o_valid(o_valid), .o_store(o_store), .o_word_addr(o_word_addr),
        .o_lane_en(o_lane_en), .o_wdata(o_wdata), .o_rdata(o_rdata), .o_fault(o_fault)
    );

    // Reference built from the requirements: for each memory position of
    // the access, which value byte it holds.
    function automatic exp_t model(int m, int s, logic [AW-1:0] addr, bit st, bit sg,
                                   logic [31:0] wd, logic [31:0] rd, string tag);
        exp_t e;
        int n;
        int off;
        int ord [4];
        logic [1:0] a;
        logic [31:0] val;
        a = addr[1:0];
        e.st = st; e.wa = addr[AW-1:2]; e.tag = tag;
        e.en = '0; e.wd = '0; e.rd = '0;
        n = (s == 0) ? 1 : (s == 1) ? 2 : 4;
        e.flt = (s == 3) || (s == 1 && a[0]) || (s == 2 && a != 2'b00);
        if (e.flt) return e;
        off = int'(a);
        if (m == 2 && s == 0) off = int'(a ^ 2'b11);
        if (m == 2 && s == 1) off = int'(a ^ 2'b10);
        for (int k = 0; k < 4; k++) begin
            if (m == 1)      ord[k] = (s == 0) ? k : n - 1 - k;
            else if (m == 3) ord[k] = (s == 2) ? (k ^ 2) : k;
            else             ord[k] = k;
        end
        val = '0;
        for (int k = 0; k < n; k++) begin
            e.en[off + k] = 1'b1;
            if (st) e.wd[8*(off + k) +: 8] = wd[8*ord[k] +: 8];
            else    val[8*ord[k] +: 8]     = rd[8*(off + k) +: 8];
        end
        if (!st) begin
            if (s == 0)      e.rd = sg ? {{24{val[7]}}, val[7:0]}   : {24'b0, val[7:0]};
            else if (s == 1) e.rd = sg ? {{16{val[15]}}, val[15:0]} : {16'b0, val[15:0]};
            else             e.rd = val;
        end
        return e;
    endfunction

    function automatic string sweep_tag(int m, int s, int a, bit st);
        bit flt;
        flt = (s == 3) || (s == 1 && (a % 2) == 1) || (s == 2 && a != 0);
        if (flt) return "R9";
        if (!st && s < 2) return "R11";
        case (m)
            0: return "R3";
            1: return (s == 0) ? "R4" : "R5";
            2: return (s == 2) ? "R6" : "R7";
            default: return "R8";
        endcase
    endfunction

    // Driver: presents one request and queues its expected result.
    task automatic send(int m, int s, logic [AW-1:0] addr, bit st, bit sg,
                        logic [31:0] wd, logic [31:0] rd, string tag);
        @(negedge clk);
        req_valid  = 1'b1;
        req_mode   = 2'(m);
        req_size   = 2'(s);
        req_addr   = addr;
        req_store  = st;
        req_signed = sg;
        req_wdata  = wd;
        bus_rdata  = rd;
        q.push_back(model(m, s, addr, st, sg, wd, rd, tag));
    endtask

    task automatic go_idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compares each valid result with the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && o_valid) begin
            exp_t e;
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R2: o_valid=%b with no request pending, expected 0", o_valid);
            end else begin
                e = q.pop_front();
                if (o_store !== e.st || o_fault !== e.flt || o_lane_en !== e.en ||
                    o_wdata !== e.wd || o_rdata !== e.rd || o_word_addr !== e.wa) begin
                    fails++;
                    $display("FAIL %s: got st=%b flt=%b en=%b wd=%h rd=%h wa=%h expected st=%b flt=%b en=%b wd=%h rd=%h wa=%h",
                             e.tag, o_store, o_fault, o_lane_en, o_wdata, o_rdata, o_word_addr,
                             e.st, e.flt, e.en, e.wd, e.rd, e.wa);
                end
            end
        end
    end

    task automatic check_bit(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    initial begin
        #500_000;
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        check_bit("R1", o_valid, 1'b0);
        checks++;
        if (o_lane_en !== 4'b0) begin
            fails++;
            $display("FAIL R1: lane_en got %b expected 0000", o_lane_en);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1", o_valid, 1'b0);

        // Directed worked values
        send(0, 0, 20'h0_1230, 1'b0, 1'b0, 32'h0, 32'h0000_004A, "R3");
        send(0, 1, 20'h0_1230, 1'b0, 1'b0, 32'h0, 32'h0000_004A, "R3");
        send(0, 2, 20'h0_1230, 1'b0, 1'b0, 32'h0, 32'h0000_004A, "R3");
        send(3, 2, 20'h0_4440, 1'b1, 1'b0, 32'h0A0B_0C0D, 32'h0, "R8");
        send(1, 2, 20'h0_4444, 1'b1, 1'b0, 32'h0A0B_0C0D, 32'h0, "R5");
        send(2, 2, 20'h0_4448, 1'b1, 1'b0, 32'h0A0B_0C0D, 32'h0, "R6");
        send(1, 0, 20'h0_5552, 1'b1, 1'b0, 32'hFFFF_FF5A, 32'h0, "R4");
        send(2, 0, 20'h0_5551, 1'b1, 1'b0, 32'hFFFF_FF5A, 32'h0, "R7");
        send(2, 1, 20'h0_5552, 1'b1, 1'b0, 32'hFFFF_1234, 32'h0, "R7");
        send(0, 0, 20'h0_6663, 1'b1, 1'b0, 32'hDEAD_BEEF, 32'h0, "R10");
        send(0, 0, 20'h0_7771, 1'b0, 1'b1, 32'h0, 32'h0000_8000, "R11");
        send(0, 0, 20'h0_7771, 1'b0, 1'b0, 32'h0, 32'h0000_8000, "R11");
        send(1, 1, 20'h0_7772, 1'b0, 1'b1, 32'h0, 32'h0180_0000, "R11");
        send(0, 1, 20'h0_8881, 1'b1, 1'b0, 32'h1234_5678, 32'h0, "R9");
        send(3, 2, 20'h0_8882, 1'b0, 1'b0, 32'h0, 32'hFFFF_FFFF, "R9");
        go_idle();
        @(negedge clk);
        // R2: an idle cycle yields no result
        check_bit("R2", o_valid, 1'b0);

        // Sweep of every mode, size code, offset, direction and sign select
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int a = 0; a < 4; a++) begin
                    for (int st = 0; st < 2; st++) begin
                        for (int sg = 0; sg < 2; sg++) begin
                            logic [AW-1:0] addr;
                            addr = AW'(((m * 64 + s * 16 + a * 4 + st * 2 + sg) << 4) | a);
                            send(m, s, addr, st[0], sg[0], 32'h8A9B_ACBD ^ (32'(m) << 8),
                                 32'hF1E2_D384 ^ (32'(s) << 20),
                                 sweep_tag(m, s, a, st[0]));
                        end
                    end
                end
            end
        end
        go_idle();
        repeat (3) @(negedge clk);
        // R2: every queued request has produced exactly one result
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d results missing, expected 0", q.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule